// File: doc/BRIEF.md
# Fan Tachometer Period Meter

This block times a slow tachometer pulse train, such as a cooling fan's speed output in the 50 Hz to 500 Hz range. It counts prescaled clock ticks between consecutive rising edges of the tach input. At each new rising edge it publishes the finished count as the period. It then converts that count to microseconds with a small multi-cycle fixed-point scaler. With the default settings a 100 MHz clock divided by 128 gives 781 250 ticks per second. A microsecond value is therefore the tick count times 1.28, which is 32/25.

The raw tach input is asynchronous. It is resynchronised before any edge is detected. A small state machine controls the measurement. The first rising edge after reset, or after a stall, only arms the measurement. Each later rising edge closes one period and opens the next.

If the count reaches a ceiling without an edge, the fan is treated as stalled or too slow. The result is zeroed and the stall flag is raised. The block then refuses to re-arm until the input has been seen low. The stall flag stays up until a complete new period has been measured.

Top module: `tach_period_meter`

## Requirements
- R1: The tach input passes through SYNC_STAGES flip-flops (two by default). Only a low-to-high change of the synchronised level starts or closes a period. A level held high does not.
- R2: A tick is issued every DIV clocks, and the tick phase restarts at every synchronised rising edge. A period of P clocks between two rising edges therefore reports period_o = floor(P / DIV).
- R3: The first rising edge after reset, or after leaving the stall wait, only arms the counter. period_o, valid_o and us_done_o do not change on that edge.
- R4: At each rising edge that closes a period shorter than the ceiling, period_o is loaded, valid_o goes to 1 and stall_o goes to 0.
- R5: When the running tick count reaches CNT_MAX, the block enters stall. In that same update period_o becomes 0, valid_o becomes 0 and stall_o becomes 1. Stall also wins when this happens in the same cycle as a rising edge, so P = DIV*CNT_MAX stalls and P = DIV*CNT_MAX-1 reports CNT_MAX-1.
- R6: While stalled, the block stays stalled as long as the synchronised input is high. Once the input is low, the next rising edge only arms the counter.
- R7: stall_o remains 1 from the stall until the next rising edge that closes a complete period.
- R8: After every update of period_o, including the zeroing on stall, period_us_o becomes floor(period_o * 2^US_SHIFT / US_DIVISOR). With the default settings this is floor(period_o * 32 / 25). us_done_o pulses high for exactly one cycle when the new value is present.
- R9: After a synchronous reset, period_o, period_us_o, valid_o, stall_o and us_done_o are all 0.
- R10: period_o never exceeds CNT_MAX-1, and valid_o and stall_o are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tach_i | input | 1 | Raw asynchronous tachometer pulse input |
| period_o | output | CNT_W | Latest period in ticks (0 after a stall) |
| period_us_o | output | CNT_W+1 | Latest period converted to microseconds |
| us_done_o | output | 1 | One-cycle strobe when period_us_o is updated |
| valid_o | output | 1 | A complete period has been measured since the last stall or reset |
| stall_o | output | 1 | Tick ceiling was reached; held until the next complete period |

## Verification
The hardest conditions to reach from the ports are the two ceiling cases. In one, the ceiling is reached on exactly the cycle of a rising edge. In the other, the ceiling is reached while the input is still held high, so the block must sit in stall until the input drops. The bench runs with a small prescaler and a small ceiling so these cases fall within a short run. Directed pulses place the closing edge exactly at DIV*CNT_MAX-1 and at DIV*CNT_MAX clocks, and one pulse keeps its high phase longer than the ceiling. Random pulse lengths between these cases cover ordinary periods and the scaling.

// File: rtl/tach_pkg.sv
package tach_pkg;
  typedef enum logic [1:0] {
    TS_IDLE  = 2'd0,
    TS_RUN   = 2'd1,
    TS_STALL = 2'd2
  } tach_state_e;
endpackage

// File: rtl/tach_sync.sv
module tach_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES-1:0] shreg;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= async_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= shreg[STAGES-1];
  end

  assign level_o = shreg[STAGES-1];
  assign rise_o  = shreg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/tach_prescaler.sv
module tach_prescaler #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] cnt_q;

  assign tick_o = (cnt_q == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tach_period_fsm.sv
module tach_period_fsm
  import tach_pkg::*;
#(
  parameter int CNT_MAX = 1048575,
  parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic             level_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] period_o,
  output logic             valid_o,
  output logic             stall_o,
  output logic             load_o,
  output tach_state_e      state_o
);
  tach_state_e      state_q;
  logic [CNT_W-1:0] count_q;
  logic             at_ceiling;

  assign at_ceiling = tick_i && (count_q == CNT_W'(CNT_MAX - 1));
  assign state_o    = state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= TS_IDLE;
      count_q  <= '0;
      period_o <= '0;
      valid_o  <= 1'b0;
      stall_o  <= 1'b0;
      load_o   <= 1'b0;
    end else begin
      load_o <= 1'b0;
      case (state_q)
        TS_IDLE: begin
          if (rise_i) begin
            count_q <= '0;
            state_q <= TS_RUN;
          end
        end
        TS_RUN: begin
          if (at_ceiling) begin
            count_q  <= '0;
            period_o <= '0;
            valid_o  <= 1'b0;
            stall_o  <= 1'b1;
            load_o   <= 1'b1;
            state_q  <= TS_STALL;
          end else if (rise_i) begin
            period_o <= count_q + CNT_W'(tick_i);
            count_q  <= '0;
            valid_o  <= 1'b1;
            stall_o  <= 1'b0;
            load_o   <= 1'b1;
          end else begin
            count_q <= count_q + CNT_W'(tick_i);
          end
        end
        TS_STALL: begin
          if (!level_i) state_q <= TS_IDLE;
        end
        default: state_q <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tach_us_scaler.sv
module tach_us_scaler #(
  parameter int IN_W    = 20,
  parameter int SHIFT   = 5,
  parameter int DIVISOR = 25,
  parameter int OUT_W   = IN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [IN_W-1:0]  value_i,
  output logic [OUT_W-1:0] us_o,
  output logic             done_o
);
  localparam int NUM_W = IN_W + SHIFT;
  localparam int RW    = $clog2(DIVISOR) + 1;
  localparam int SW    = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q, quo_nxt;
  logic [RW-1:0]    rem_q, rem_nxt, trial;
  logic [SW-1:0]    steps_q;
  logic             busy_q;
  logic             fits;

  always_comb begin
    trial   = {rem_q[RW-2:0], quo_q[NUM_W-1]};
    fits    = (trial >= RW'(DIVISOR));
    rem_nxt = fits ? (trial - RW'(DIVISOR)) : trial;
    quo_nxt = {quo_q[NUM_W-2:0], fits};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      quo_q   <= '0;
      rem_q   <= '0;
      steps_q <= '0;
      busy_q  <= 1'b0;
      us_o    <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        quo_q   <= {value_i, {SHIFT{1'b0}}};
        rem_q   <= '0;
        steps_q <= SW'(NUM_W);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        quo_q   <= quo_nxt;
        rem_q   <= rem_nxt;
        steps_q <= steps_q - 1'b1;
        if (steps_q == SW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          us_o   <= quo_nxt[OUT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/tach_period_meter.sv
module tach_period_meter
  import tach_pkg::*;
#(
  parameter int DIV         = 128,
  parameter int CNT_MAX     = 1048575,
  parameter int SYNC_STAGES = 2,
  parameter int US_SHIFT    = 5,
  parameter int US_DIVISOR  = 25,
  parameter int CNT_W       = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tach_i,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W:0]   period_us_o,
  output logic             us_done_o,
  output logic             valid_o,
  output logic             stall_o
);
  logic        level_w, rise_w, tick_w, load_w;
  tach_state_e st_w;

  tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(tach_i),
    .level_o(level_w), .rise_o(rise_w)
  );

  tach_prescaler #(.DIV(DIV)) u_presc (
    .clk(clk), .rst(rst), .clear_i(rise_w), .tick_o(tick_w)
  );

  tach_period_fsm #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .rise_i(rise_w), .level_i(level_w),
    .tick_i(tick_w), .period_o(period_o), .valid_o(valid_o),
    .stall_o(stall_o), .load_o(load_w), .state_o(st_w)
  );

  tach_us_scaler #(.IN_W(CNT_W), .SHIFT(US_SHIFT), .DIVISOR(US_DIVISOR),
                   .OUT_W(CNT_W + 1)) u_scale (
    .clk(clk), .rst(rst), .start_i(load_w), .value_i(period_o),
    .us_o(period_us_o), .done_o(us_done_o)
  );
endmodule

// File: rtl/tach_period_meter_chk.sv
module tach_period_meter_chk
  import tach_pkg::*;
#(
  parameter int CNT_MAX = 1048575,
  parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             rise,
  input logic             level,
  input tach_state_e      state,
  input logic [CNT_W-1:0] period_o,
  input logic             valid_o,
  input logic             stall_o,
  input logic             us_done_o
);
  assert_excl_flags_R10: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && stall_o));

  assert_period_bound_R10: assert property (@(posedge clk) disable iff (rst)
    period_o < CNT_W'(CNT_MAX));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state == TS_STALL && level) |=> (state == TS_STALL));

  assert_stall_leave_R6: assert property (@(posedge clk) disable iff (rst)
    (state == TS_STALL && !level) |=> (state == TS_IDLE));

  assert_arm_only_R3: assert property (@(posedge clk) disable iff (rst)
    (state == TS_IDLE && rise) |=> ($stable(valid_o) && $stable(period_o)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    us_done_o |=> !us_done_o);

  assert_period_change_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(period_o) |-> ($past(rise) || stall_o));

  assert_stall_zero_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_o) |-> (period_o == '0 && !valid_o));
endmodule

bind tach_period_meter tach_period_meter_chk #(.CNT_MAX(CNT_MAX), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rise(rise_w), .level(level_w), .state(st_w),
  .period_o(period_o), .valid_o(valid_o), .stall_o(stall_o),
  .us_done_o(us_done_o)
);

// File: tb/tach_period_meter_test.sv
module tach_period_meter_test;
  localparam int DIV  = 4;
  localparam int CMAX = 200;
  localparam int CW   = $clog2(CMAX + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tach = 1'b0;
  logic [CW-1:0] period_o;
  logic [CW:0]   period_us_o;
  logic          us_done_o, valid_o, stall_o;

  int checks = 0;
  int errors = 0;
  int bst    = 0;   // 0 waiting to arm, 1 counting
  int prev_p = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  tach_period_meter #(.DIV(DIV), .CNT_MAX(CMAX)) uut (
    .clk(clk), .rst(rst), .tach_i(tach), .period_o(period_o),
    .period_us_o(period_us_o), .us_done_o(us_done_o),
    .valid_o(valid_o), .stall_o(stall_o)
  );

  function automatic int exp_us(int r);
    return (r * 32) / 25;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int h, int l);
    bit exp_res = 0, exp_stall_edge = 0, seen = 0;
    int cap_p = 0, cap_us = 0, cap_v = 0, cap_s = 0;
    int v_before, p_before;
    if (bst == 1 && prev_p > DIV * CMAX) begin
      chk(stall_o == 1'b1, "R5 stall flag before edge", stall_o, 1);
      chk(valid_o == 1'b0, "R5 valid cleared", valid_o, 0);
      chk(period_o == '0, "R5 period zeroed", period_o, 0);
      chk(period_us_o == '0, "R8 us zeroed", period_us_o, 0);
      bst = 0;
    end
    if (bst == 1) begin
      if (prev_p == DIV * CMAX) exp_stall_edge = 1;
      else exp_res = 1;
    end
    v_before = valid_o;
    p_before = period_o;
    tach = 1'b1;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      if (us_done_o && !seen && i < 50) begin
        seen = 1; cap_p = period_o; cap_us = period_us_o;
        cap_v = valid_o; cap_s = stall_o;
      end
    end
    tach = 1'b0;
    for (int i = 0; i < l; i++) @(negedge clk);
    if (exp_res) begin
      chk(seen, "R8 done strobe after period", seen, 1);
      chk(cap_p == prev_p / DIV, "R2 period ticks", cap_p, prev_p / DIV);
      chk(cap_us == exp_us(prev_p / DIV), "R8 us value", cap_us, exp_us(prev_p / DIV));
      chk(cap_v == 1 && cap_s == 0, "R4 R7 valid set stall clear", cap_v * 2 + cap_s, 2);
      bst = 1;
    end else if (exp_stall_edge) begin
      chk(seen, "R5 done on stall at edge", seen, 1);
      chk(cap_p == 0 && cap_us == 0, "R5 zero at ceiling edge", cap_p + cap_us, 0);
      chk(cap_s == 1 && cap_v == 0, "R5 stall wins over edge", cap_s * 2 + cap_v, 2);
      chk(stall_o == 1'b1, "R7 stall held after low", stall_o, 1);
      bst = 0;
    end else begin
      chk(!seen, "R3 R6 arming edge gives no result", seen, 0);
      chk(valid_o == v_before[0], "R3 valid unchanged on arm", valid_o, v_before);
      chk(period_o == p_before[CW-1:0], "R3 period unchanged on arm", period_o, p_before);
      bst = 1;
    end
    prev_p = h + l;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5eed_7a11);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(period_o == '0 && period_us_o == '0, "R9 reset outputs", period_o + period_us_o, 0);
    chk(!valid_o && !stall_o && !us_done_o, "R9 reset flags", valid_o + stall_o + us_done_o, 0);

    pulse(60, 100);                      // arm (R3)
    pulse(60, 140);                      // closes 160 clocks -> 40 (R2)
    for (int k = 0; k < 20; k++) begin
      pulse(50 + int'($urandom_range(70)), 20 + int'($urandom_range(580)));
    end
    pulse(50, 749);                      // 799 clocks -> CMAX-1
    pulse(50, 750);                      // 800 clocks -> stall at edge
    pulse(60, 100);                      // closes stall case (R5, R7)
    pulse(60, 100);                      // arm after stall (R6)
    pulse(900, 50);                      // result, then stall while high (R1, R6)
    pulse(60, 100);                      // stall check, then arm
    pulse(60, 60);                       // result 40 (R7 cleared)
    pulse(50, 1000);                     // result 30, then stall in low phase
    pulse(70, 90);                       // arm
    pulse(70, 50);                       // result 40
    pulse(60, 60);                       // result 30

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule